// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block collects edge-triggered requests from a set of maskable sources and from one non-maskable source (NMI). It filters them through per-source enables and the CPU mask state. It then presents a single registered winner to the CPU: a pending flag, the winning source number and a flag that marks the NMI as the winner. The CPU answers with a one-cycle acknowledge pulse. The pulse retires the granted request and starts a fresh arbitration.

Masking has two modes, chosen by a mode input. In single-mask mode one mask bit turns all maskable sources on or off together. In two-bit mode a second mask bit is added, which gives three nested acceptance levels: every source, high-level sources only, or NMI only. Each source carries one priority-level bit. Level 1 always beats level 0, and within a level the lowest source number wins. The NMI beats every maskable source. While the device is held in reset or in standby, no request is accepted and latched requests are discarded.

Top module: `mlvl_intc`

## Requirements
- R1: After reset, and from the clock edge after `stby_i` goes high, `irq_pend_o`, `irq_nmi_o` and `irq_idx_o` read 0. Latched requests are discarded, and rising edges seen while `stby_i` is high are never presented.
- R2: With `mode_ue_i`=1, `mask_i`=0 accepts every enabled source and `mask_i`=1 accepts only the NMI, whatever `mask_ui_i` is.
- R3: With `mode_ue_i`=0 and `mask_i`=0, every enabled source is accepted, whatever `mask_ui_i` is.
- R4: With `mode_ue_i`=0, `mask_i`=1 and `mask_ui_i`=0, only the NMI and sources whose `lvl_i` bit is 1 are accepted. Level-0 requests stay latched but are held off.
- R5: With `mode_ue_i`=0, `mask_i`=1 and `mask_ui_i`=1, only the NMI is accepted.
- R6: A rising edge on `req_i[k]` while `en_i[k]`=0 is not latched, so setting `en_i[k]` afterwards presents nothing.
- R7: Among accepted maskable requests, a source with `lvl_i` bit 1 wins over any with bit 0. Within the same level, the lowest index wins.
- R8: A latched NMI wins over every maskable request. It is presented with `irq_nmi_o`=1 and `irq_idx_o`=0.
- R9: While `irq_pend_o` is 1, the outputs hold until `ack_i` is sampled high. At that edge the outputs clear and only the granted request is retired. The next winner appears one edge later. A new rising edge on the granted source in the acknowledge cycle stays latched.
- R10: Requests are latched on a rising edge of their input and stay pending while masked. Changing the mask or enable inputs clears no latched request, and a change takes effect at the next clock edge.
- R11: When a rising edge is sampled at clock edge n, the winner is presented after edge n+1, provided no request is already presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stby_i | input | 1 | Hardware standby status, active high |
| req_i | input | NSRC | Maskable request lines, edge sensitive |
| en_i | input | NSRC | Per-source enable |
| lvl_i | input | NSRC | Per-source priority level (1 = high) |
| nmi_i | input | 1 | Non-maskable request line, edge sensitive |
| mode_ue_i | input | 1 | 1 = single-mask mode, 0 = two-bit mode |
| mask_i | input | 1 | Primary CPU mask bit |
| mask_ui_i | input | 1 | Secondary CPU mask bit (two-bit mode only) |
| ack_i | input | 1 | One-cycle acknowledge from the CPU |
| irq_pend_o | output | 1 | A winner is being presented |
| irq_idx_o | output | IDX_W | Winning source index (0 when NMI or idle) |
| irq_nmi_o | output | 1 | The presented winner is the NMI |

## Verification
Two functions can land in the same cycle: the acknowledge that retires a granted source, and a fresh rising edge on that same source. The bench drives the acknowledge pulse and a new edge on the granted line in one cycle. It then expects `irq_pend_o` low for exactly one cycle, followed by the same index again, which shows that the new edge won over the clear. A second overlap happens when the NMI and a maskable request are latched at the same edge. That case is judged by the NMI being presented first and the maskable source surviving to be presented after the acknowledge.

// File: rtl/mlvl_intc_pkg.sv
package mlvl_intc_pkg;

  // Acceptance class produced by the mask decode
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,   // NMI only
    ACC_HIGH = 2'd1,   // NMI and level-1 sources
    ACC_ALL  = 2'd2    // every enabled source
  } acc_e;

  function automatic acc_e acc_decode(input logic ue, input logic m, input logic mu);
    acc_e r;
    if (!m)
      r = ACC_ALL;
    else if (ue)
      r = ACC_NONE;
    else if (!mu)
      r = ACC_HIGH;
    else
      r = ACC_NONE;
    return r;
  endfunction

endpackage

// File: rtl/mlvl_intc_latch.sv
module mlvl_intc_latch #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stby_i,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            nmi_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            clr_nmi_i,
  output logic [NSRC-1:0] pend_o,
  output logic            nmi_pend_o
);

  logic [NSRC-1:0] prev_q, prev_d;
  logic [NSRC-1:0] pend_q, pend_d;
  logic            nprev_q, nprev_d;
  logic            npend_q, npend_d;
  logic [NSRC-1:0] rise;
  logic            nrise;

  always_comb begin
    rise    = req_i & ~prev_q & en_i;
    nrise   = nmi_i & ~nprev_q;
    prev_d  = req_i;
    nprev_d = nmi_i;
    if (stby_i) begin
      pend_d  = '0;
      npend_d = 1'b0;
    end else begin
      // a new edge wins over a clear in the same cycle
      pend_d  = (pend_q & ~clr_i) | rise;
      npend_d = (npend_q & ~clr_nmi_i) | nrise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      nprev_q <= 1'b0;
      pend_q  <= '0;
      npend_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      nprev_q <= nprev_d;
      pend_q  <= pend_d;
      npend_q <= npend_d;
    end
  end

  assign pend_o     = pend_q;
  assign nmi_pend_o = npend_q;

endmodule

// File: rtl/mlvl_intc_mask.sv
module mlvl_intc_mask
  import mlvl_intc_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] lvl_i,
  input  logic            mode_ue_i,
  input  logic            mask_i,
  input  logic            mask_ui_i,
  output logic [NSRC-1:0] cand_o
);

  acc_e acc;
  logic take_all;
  logic take_high;

  always_comb begin
    acc       = acc_decode(mode_ue_i, mask_i, mask_ui_i);
    take_all  = (acc == ACC_ALL);
    take_high = (acc == ACC_HIGH);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_cand
    assign cand_o[g] = pend_i[g] & en_i[g] & (take_all | (take_high & lvl_i[g]));
  end

endmodule

// File: rtl/mlvl_intc_select.sv
module mlvl_intc_select #(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  cand_i,
  input  logic [NSRC-1:0]  lvl_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [NSRC-1:0]  hi_v, lo_v;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_v   = cand_i & lvl_i;
    lo_v   = cand_i & ~lvl_i;
    hi_idx = '0;
    lo_idx = '0;
    // scan downward so the lowest set index is the last written
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hi_v[i]) hi_idx = IDX_W'(i);
      if (lo_v[i]) lo_idx = IDX_W'(i);
    end
    found_o = |cand_i;
    idx_o   = (|hi_v) ? hi_idx : lo_idx;
  end

  // R7: a reported winner is always an accepted request
  always_comb begin
    if (found_o) p_win_is_cand_r7: assert (cand_i[idx_o]);
  end

endmodule

// File: rtl/mlvl_intc.sv
module mlvl_intc #(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby_i,
  input  logic [NSRC-1:0]  req_i,
  input  logic [NSRC-1:0]  en_i,
  input  logic [NSRC-1:0]  lvl_i,
  input  logic             nmi_i,
  input  logic             mode_ue_i,
  input  logic             mask_i,
  input  logic             mask_ui_i,
  input  logic             ack_i,
  output logic             irq_pend_o,
  output logic [IDX_W-1:0] irq_idx_o,
  output logic             irq_nmi_o
);

  localparam logic [NSRC-1:0] ONE_HOT0 = {{(NSRC-1){1'b0}}, 1'b1};

  // reset: asserted asynchronously, released on the clock
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  logic [NSRC-1:0]  pend, cand, clr;
  logic             nmi_pend, clr_nmi;
  logic             found;
  logic [IDX_W-1:0] sel_idx;

  logic             out_v_q, out_v_d;
  logic             out_n_q, out_n_d;
  logic [IDX_W-1:0] out_i_q, out_i_d;
  logic             out_en;
  logic             retire;

  mlvl_intc_latch #(.NSRC(NSRC)) u_latch (
    .clk       (clk),
    .rst_n     (rs_q),
    .stby_i    (stby_i),
    .req_i     (req_i),
    .en_i      (en_i),
    .nmi_i     (nmi_i),
    .clr_i     (clr),
    .clr_nmi_i (clr_nmi),
    .pend_o    (pend),
    .nmi_pend_o(nmi_pend)
  );

  mlvl_intc_mask #(.NSRC(NSRC)) u_mask (
    .pend_i    (pend),
    .en_i      (en_i),
    .lvl_i     (lvl_i),
    .mode_ue_i (mode_ue_i),
    .mask_i    (mask_i),
    .mask_ui_i (mask_ui_i),
    .cand_o    (cand)
  );

  mlvl_intc_select #(.NSRC(NSRC), .IDX_W(IDX_W)) u_sel (
    .cand_i  (cand),
    .lvl_i   (lvl_i),
    .found_o (found),
    .idx_o   (sel_idx)
  );

  // acknowledge retires only the granted request
  always_comb begin
    retire  = out_v_q & ack_i & ~stby_i;
    clr     = (retire & ~out_n_q) ? (ONE_HOT0 << out_i_q) : '0;
    clr_nmi = retire & out_n_q;
  end

  // output register: loads when idle, holds while presented
  always_comb begin
    out_en  = stby_i | ~out_v_q | ack_i;
    out_v_d = 1'b0;
    out_n_d = 1'b0;
    out_i_d = '0;
    if (!stby_i && !out_v_q) begin
      out_v_d = nmi_pend | found;
      out_n_d = nmi_pend;
      out_i_d = nmi_pend ? '0 : sel_idx;
    end
  end

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      out_v_q <= 1'b0;
      out_n_q <= 1'b0;
      out_i_q <= '0;
    end else if (out_en) begin
      out_v_q <= out_v_d;
      out_n_q <= out_n_d;
      out_i_q <= out_i_d;
    end
  end

  assign irq_pend_o = out_v_q;
  assign irq_nmi_o  = out_n_q;
  assign irq_idx_o  = out_i_q;

  // R9: presented winner holds until acknowledged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rs_q)
    (out_v_q && !ack_i && !stby_i) |=> (out_v_q && $stable(out_i_q) && $stable(out_n_q)));

  // R1: standby empties the output
  p_stby_quiet_r1: assert property (@(posedge clk) disable iff (!rs_q)
    stby_i |=> !out_v_q);

  // R8: an idle output with a latched NMI presents the NMI
  p_nmi_first_r8: assert property (@(posedge clk) disable iff (!rs_q)
    (!out_v_q && !stby_i && nmi_pend) |=> (out_v_q && out_n_q));

  // R2: single-mask mode with mask set admits no maskable source
  p_global_mask_r2: assert property (@(posedge clk) disable iff (!rs_q)
    (!out_v_q && !stby_i && mode_ue_i && mask_i && !nmi_pend) |=> !out_v_q);

  // R5: two-bit mode with both bits set admits no maskable source
  p_full_mask_r5: assert property (@(posedge clk) disable iff (!rs_q)
    (!out_v_q && !stby_i && !mode_ue_i && mask_i && mask_ui_i && !nmi_pend) |=> !out_v_q);

endmodule

// File: tb/sim_mlvl_intc.sv
module sim_mlvl_intc;

  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stby;
  logic [N-1:0]  req, en, lvl;
  logic          nmi, ue, m, mu, ack;
  logic          pend_o, nmi_o;
  logic [IW-1:0] idx_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mlvl_intc #(.NSRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .stby_i(stby), .req_i(req), .en_i(en),
    .lvl_i(lvl), .nmi_i(nmi), .mode_ue_i(ue), .mask_i(m), .mask_ui_i(mu),
    .ack_i(ack), .irq_pend_o(pend_o), .irq_idx_o(idx_o), .irq_nmi_o(nmi_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic ep, input logic en_, input int ei);
    checks++;
    if (pend_o !== ep || nmi_o !== en_ || int'(idx_o) != ei) begin
      errors++;
      $display("FAIL %s: got pend=%b nmi=%b idx=%0d, expected pend=%b nmi=%b idx=%0d",
               tag, pend_o, nmi_o, idx_o, ep, en_, ei);
    end
  endtask

  // edge on the chosen lines, one cycle wide; returns after the presenting edge
  task automatic raise(input logic [N-1:0] v, input logic n_);
    req = req | v; nmi = n_;
    step(1);
    req = req & ~v; nmi = 1'b0;
    step(1);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  task automatic flush();
    stby = 1'b1; step(1);
    stby = 1'b0; step(1);
  endtask

  task automatic t_reset();
    chk("R1 reset state", 0, 0, 0);
  endtask

  task automatic t_single_mask();
    ue = 1; m = 0; mu = 1; lvl = '0;
    raise(8'h08, 0);
    chk("R2 ue=1 i=0 accepts", 1, 0, 3);
    flush();
    m = 1; lvl = 8'h04;
    raise(8'h04, 0);
    chk("R2 ue=1 i=1 blocks level1", 0, 0, 0);
    m = 0; step(1);
    chk("R10 latched while masked, shown on unmask", 1, 0, 2);
    flush();
  endtask

  task automatic t_two_bit_open();
    ue = 0; m = 0; mu = 1; lvl = '0;
    raise(8'h20, 0);
    chk("R3 ue=0 i=0 ui=1 accepts", 1, 0, 5);
    flush();
  endtask

  task automatic t_high_only();
    ue = 0; m = 1; mu = 0; lvl = 8'h40;
    raise(8'h42, 0);
    chk("R4 level1 admitted", 1, 0, 6);
    do_ack();
    chk("R9 cleared in ack cycle", 0, 0, 0);
    step(1);
    chk("R4 level0 held off", 0, 0, 0);
    m = 0; step(1);
    chk("R10 held level0 shown after unmask", 1, 0, 1);
    flush();
  endtask

  task automatic t_nmi_only();
    ue = 0; m = 1; mu = 1; lvl = 8'h40;
    raise(8'h40, 0);
    chk("R5 level1 blocked", 0, 0, 0);
    raise('0, 1);
    chk("R5 NMI still accepted", 1, 1, 0);
    flush();
  endtask

  task automatic t_enable();
    ue = 0; m = 0; mu = 0; lvl = '0; en = 8'hEF;
    raise(8'h10, 0);
    chk("R6 disabled edge ignored", 0, 0, 0);
    en = 8'hFF; step(1);
    chk("R6 enabling later shows nothing", 0, 0, 0);
    flush();
  endtask

  task automatic t_priority();
    ue = 1; m = 0; lvl = 8'h80;
    raise(8'hA4, 0);
    chk("R7 level1 wins", 1, 0, 7);
    do_ack(); step(1);
    chk("R7 lowest level0 next", 1, 0, 2);
    do_ack(); step(1);
    chk("R7 remaining level0", 1, 0, 5);
    do_ack(); step(1);
    chk("R9 only granted retired, now empty", 0, 0, 0);
    flush();
  endtask

  task automatic t_nmi_wins();
    ue = 1; m = 0; lvl = 8'h01;
    raise(8'h01, 1);
    chk("R8 NMI over level1", 1, 1, 0);
    do_ack(); step(1);
    chk("R8 maskable survives NMI ack", 1, 0, 0);
    flush();
  endtask

  task automatic t_hold_and_collide();
    ue = 1; m = 0; lvl = 8'h02;
    raise(8'h08, 0);
    chk("R9 first winner", 1, 0, 3);
    raise(8'h02, 0);
    chk("R9 held against higher request", 1, 0, 3);
    do_ack(); step(1);
    chk("R9 new arbitration after ack", 1, 0, 1);
    // ack and fresh edge on granted source in one cycle
    ack = 1'b1; req = 8'h02; step(1);
    ack = 1'b0; req = '0;
    chk("R9 collide: gap cycle", 0, 0, 0);
    step(1);
    chk("R9 collide: new edge kept", 1, 0, 1);
    flush();
  endtask

  task automatic t_timing();
    ue = 1; m = 0; lvl = '0;
    req = 8'h40; step(1);
    chk("R11 not yet after first edge", 0, 0, 0);
    req = '0; step(1);
    chk("R11 shown after second edge", 1, 0, 6);
    flush();
  endtask

  task automatic t_standby();
    ue = 1; m = 0; lvl = '0;
    raise(8'h01, 0);
    stby = 1'b1; step(1);
    chk("R1 standby clears output", 0, 0, 0);
    req = 8'h04; nmi = 1'b1; step(1);
    req = '0; nmi = 1'b0; step(1);
    stby = 1'b0; step(2);
    chk("R1 edges in standby discarded", 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stby = 1'b0; req = '0; en = '1; lvl = '0;
    nmi = 1'b0; ue = 1'b1; m = 1'b0; mu = 1'b0; ack = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_single_mask();
    t_two_bit_open();
    t_high_only();
    t_nmi_only();
    t_enable();
    t_priority();
    t_nmi_wins();
    t_hold_and_collide();
    t_timing();
    t_standby();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule